// File: doc/BRIEF.md
# Serial Cyclic Check Generator and Verifier

A bit-serial 16-bit cyclic check register, preset to all ones, built on the polynomial x^16 + x^12 + x^5 + 1. A record is written one bit per accepted input beat. Each bit is absorbed into the register through a feedback term. That term is the XOR of the incoming bit with the top position. The feedback goes into position 0, and it is also XORed into the bits shifted into positions 5 and 12.

To write check bytes, the host raises `emit`. The feedback XORs are then switched off. The register shifts its stored value out on an output stream, top position first, for exactly sixteen beats.

To verify a record, the host presets the register and sends the data bits followed by the sixteen received check bits. Both go through the same input stream as in writing. It then pulses `end_check`. The error flag samples whether any register position is still set. The `crc_zero` output shows the live all-zero state at every cycle.

The input stream is valid/ready. `s_ready` is high whenever `emit` is low, and a bit is absorbed only in a cycle where `s_valid` and `s_ready` are both high. The output stream is also valid/ready. While `emit` is high, `m_valid` stays high until sixteen beats have been taken. A beat is taken in a cycle where `m_valid` and `m_ready` are both high. When `m_ready` is low, the register and `m_bit` hold. The control inputs `init`, `emit` and `end_check` are plain levels or strobes.

Top module: `crc16_serial`

## Requirements
- R1: After reset or an `init` pulse, every register position is one, `err` is 0 and `crc_zero` is 0.
- R2: Each input beat (`s_valid` and `s_ready` high) shifts the register once with feedback equal to `s_bit` XOR the top position. Over a message sent most significant bit first from the preset, the result equals the standard CCITT-FALSE value, for example 0x29B1 for ASCII "123456789".
- R3: While `emit` is high, `s_ready` is 0 and `m_valid` is 1 for exactly 16 beats. `m_bit` carries the register, most significant bit first, with no feedback applied. Once the 16 beats are taken `m_valid` drops to 0, and it stays 0 whenever `emit` is low.
- R4: While `m_valid` is 1 and `m_ready` is 0, the register, `m_bit` and the remaining beat count hold.
- R5: `s_valid` and `s_bit` have no effect while `emit` is high.
- R6: `init` takes priority over any beat in the same cycle.
- R7: Feeding a message followed by its own 16 check bits leaves the register all zero: `crc_zero` is 1, and `err` is 0 after `end_check`.
- R8: If any single bit of a message or of its check bits is inverted, `err` is 1 after `end_check`.
- R9: `err` changes only on an `end_check` or `init` cycle, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Preset register to all ones, clear error |
| emit | input | 1 | Suppress feedback and stream the register out |
| end_check | input | 1 | Sample the error flag from the register |
| s_valid | input | 1 | Input bit valid |
| s_ready | output | 1 | Input bit accepted (high while not emitting) |
| s_bit | input | 1 | Input data or check bit |
| m_valid | output | 1 | Output check bit valid |
| m_ready | input | 1 | Downstream takes the output bit |
| m_bit | output | 1 | Output check bit, top position |
| crc_zero | output | 1 | Register currently all zero |
| err | output | 1 | Error flag sampled at `end_check` |

## Verification
The properties assume that `emit` is held for a whole emission once it is raised. They also assume that `init` is not pulsed partway through a stall. The stall-hold property is phrased so that it does not cover the cycle in which `emit` falls. The stimulus changes inputs only on falling edges. It keeps `emit` high through the 16 beats and one further cycle, and it pulses `init` and `end_check` only between streams, except for the deliberate same-cycle test of `init` priority.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY   = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_PRESET = '1;
endpackage

// File: rtl/crc16_step.sv
module crc16_step #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic [W-1:0] crc_i,
  input  logic         bit_i,
  input  logic         xor_en,
  output logic [W-1:0] crc_o
);
  logic fb;
  assign fb = xor_en & (bit_i ^ crc_i[W-1]);

  for (genvar b = 0; b < W; b++) begin : g_pos
    if (b == 0) begin : g_low
      assign crc_o[b] = POLY[b] & fb;
    end else begin : g_up
      assign crc_o[b] = crc_i[b-1] ^ (POLY[b] & fb);
    end
  end
endmodule

// File: rtl/crc16_emit_ctrl.sv
module crc16_emit_ctrl #(
  parameter int unsigned W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic emit,
  input  logic m_ready,
  output logic m_valid,
  output logic beat
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [CW-1:0] sent_q;

  assign m_valid = emit && (sent_q != LAST);
  assign beat    = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || init || !emit) begin
      sent_q <= '0;
    end else if (beat) begin
      sent_q <= sent_q + 1'b1;
    end
  end
endmodule

// File: rtl/crc16_serial.sv
module crc16_serial
  import crc16_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY,
  parameter logic [W-1:0] PRESET = CRC_PRESET
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic emit,
  input  logic end_check,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_bit,
  output logic m_valid,
  input  logic m_ready,
  output logic m_bit,
  output logic crc_zero,
  output logic err
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_nx;
  logic         absorb;
  logic         beat;
  logic         shift_en;

  assign s_ready  = !emit;
  assign absorb   = s_valid && s_ready;
  assign shift_en = absorb || beat;
  assign m_bit    = crc_q[W-1];
  assign crc_zero = (crc_q == '0);

  crc16_step #(.W(W), .POLY(POLY)) u_step (
    .crc_i (crc_q),
    .bit_i (s_bit),
    .xor_en(!emit),
    .crc_o (crc_nx)
  );

  crc16_emit_ctrl #(.W(W)) u_emit (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (init),
    .emit   (emit),
    .m_ready(m_ready),
    .m_valid(m_valid),
    .beat   (beat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      crc_q <= PRESET;
    end else if (shift_en) begin
      crc_q <= crc_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      err <= 1'b0;
    end else if (end_check) begin
      err <= |crc_q;
    end
  end
endmodule

// File: rtl/crc16_serial_chk.sv
module crc16_serial_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         init,
  input logic         emit,
  input logic         end_check,
  input logic         s_ready,
  input logic         m_valid,
  input logic         m_ready,
  input logic         m_bit,
  input logic         err,
  input logic [W-1:0] crc
);
  localparam int unsigned CW = $clog2(W + 2);
  logic [CW-1:0] taken;

  always_ff @(posedge clk) begin
    if (!rst_n || init || !emit) taken <= '0;
    else if (m_valid && m_ready) taken <= taken + 1'b1;
  end

  assert_preset_after_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc == '1 && !err));

  assert_no_input_when_emitting_R5: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> !s_ready);

  assert_idle_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |-> !m_valid);

  assert_beat_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && taken == CW'(W)) |-> !m_valid);

  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !init) |=> (!emit || ($stable(m_bit) && $stable(crc))));

  assert_err_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!end_check && !init) |=> $stable(err));
endmodule

bind crc16_serial crc16_serial_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .init     (init),
  .emit     (emit),
  .end_check(end_check),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_bit    (m_bit),
  .err      (err),
  .crc      (crc_q)
);

// File: tb/test_crc16_serial.sv
module test_crc16_serial;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [71:0] VEC_MSG [NV] = '{
    72'h313233343536373839, 72'h0, 72'h00 << 64, 72'hFF << 64,
    72'hA5C3 << 56, 72'hDEADBEEF << 40 };
  localparam int VEC_LEN [NV] = '{9, 0, 1, 1, 2, 4};

  logic clk = 0, rst_n = 0, init = 0, emit = 0, end_check = 0;
  logic s_valid = 0, s_bit = 0, m_ready = 0;
  logic s_ready, m_valid, m_bit, crc_zero, err;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_serial i_crc16_serial (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [87:0] v, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[15];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
    end
    return c;
  endfunction

  task automatic do_init();
    @(negedge clk); init = 1;
    @(negedge clk); init = 0;
  endtask

  task automatic feed(input logic [87:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); s_valid = 1; s_bit = v[i];
    end
    @(negedge clk); s_valid = 0; s_bit = 0;
  endtask

  task automatic collect(output logic [15:0] w, output bit vld_ok, output bit drop_ok);
    w = '0; vld_ok = 1;
    @(negedge clk); emit = 1; m_ready = 1;
    for (int i = 0; i < 16; i++) begin
      #1;
      w = {w[14:0], m_bit};
      vld_ok &= m_valid & !s_ready;
      @(negedge clk);
    end
    #1 drop_ok = !m_valid;
    @(negedge clk); emit = 0; m_ready = 0;
  endtask

  task automatic do_end_check();
    @(negedge clk); end_check = 1;
    @(negedge clk); end_check = 0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] w, e;
    logic [87:0] d;
    bit vok, dok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk(!crc_zero && !err && s_ready && !m_valid, "R1 reset", {crc_zero, err, s_ready, m_valid}, 4'b0010);
    collect(w, vok, dok);
    chk(w == 16'hFFFF, "R1 preset ones", w, 16'hFFFF);

    // R2 anchor value
    do_init();
    feed({16'h0, VEC_MSG[0]}, 72);
    collect(w, vok, dok);
    chk(w == 16'h29B1, "R2 known check", w, 16'h29B1);

    for (int k = 0; k < NV; k++) begin
      d = {16'h0, VEC_MSG[k]} >> (72 - 8 * VEC_LEN[k]);
      e = ref_crc(d, 8 * VEC_LEN[k]);
      do_init();
      feed(d, 8 * VEC_LEN[k]);
      collect(w, vok, dok);
      chk(w == e, "R2 generate", w, e);
      chk(vok && dok, "R3 sixteen beats", {vok, dok}, 2'b11);
      do_init();
      feed((d << 16) | {72'h0, e}, 8 * VEC_LEN[k] + 16);
      chk(crc_zero, "R7 zero residue", crc_zero, 1);
      do_end_check();
      chk(!err, "R7 no error", err, 0);
      do_init();
      feed(((d << 16) | {72'h0, e}) ^ (88'h1 << (8 * VEC_LEN[k] + 15)), 8 * VEC_LEN[k] + 16);
      do_end_check();
      chk(err, "R8 corrupted", err, 1);
    end

    // R9: err holds while bits flow without end_check
    feed(88'h5A, 8);
    #1 chk(err, "R9 err held", err, 1);
    do_init();
    #1 chk(!err, "R1 init clears err", err, 0);

    // R4: stall holds register and bit
    @(negedge clk); emit = 1; m_ready = 0;
    repeat (3) @(negedge clk);
    #1 chk(m_valid && m_bit, "R4 stall", {m_valid, m_bit}, 2'b11);
    @(negedge clk); emit = 0;
    collect(w, vok, dok);
    chk(w == 16'hFFFF, "R4 no shift when stalled", w, 16'hFFFF);

    // R5: input ignored while emitting
    do_init();
    feed(88'h41, 8);
    e = ref_crc(88'h41, 8);
    @(negedge clk); emit = 1; m_ready = 1; s_valid = 1; s_bit = 1;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      #1 w = {w[14:0], m_bit};
      @(negedge clk); s_bit = ~s_bit;
    end
    emit = 0; m_ready = 0; s_valid = 0;
    chk(w == e, "R5 input ignored", w, e);

    // R6: init wins over a same-cycle beat
    do_init();
    feed(88'h3C, 8);
    @(negedge clk); init = 1; s_valid = 1; s_bit = 1;
    @(negedge clk); init = 0; s_valid = 0;
    collect(w, vok, dok);
    chk(w == 16'hFFFF, "R6 init priority", w, 16'hFFFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule